// File: doc/BRIEF.md
# Pipelined Multibit Trie Route Lookup

This block resolves a destination address to a next-hop port by walking a multibit trie, one level per pipeline stage. The address is cut into fixed-width chunks, most significant first; each stage uses its chunk to pick one entry from an array in its own level memory. An entry can record a port for each prefix length that ends inside its chunk, and it can point on to an array in the next level. A skip marker lets a level hold a one-entry array that only serves an all-zero chunk.

A new address may enter on every clock. A result leaves the last stage a fixed number of cycles later, in entry order. It carries the deepest port found along the walk, or a miss. Routing software fills the level memories one entry at a time through a write port, and the write port never holds up lookups.

Top module: `trie_lookup`

## Requirements
- R1: Level i (0 = first) indexes its array with the next STRIDES[i] address bits below those used by earlier levels, starting at the MSB. Level 0 always reads array 0. Parameter field i of STRIDES is bits [8i+7:8i].
- R2: The entry word, LSB first, is: SLOT_N port slots of PORT_W bits each (slot k at [k*PORT_W +: PORT_W]); SLOT_N slot-valid bits; a pointer of PTR_W bits; the indicator bit; the skip bit as the MSB. Within one entry, the valid slot with the highest index below that level's stride supplies the level's port.
- R3: When the indicator is 1, the next level reads the array named by the pointer. When it is 0, the walk ends and later levels add nothing.
- R4: A port found at a deeper level replaces the one carried from shallower levels. A level without a valid slot keeps the carried port.
- R5: When the skip bit is 1 and the next level's chunk is zero, that level reads entry 0 of the pointed array. If that chunk is nonzero, the walk ends there and the carried port stands.
- R6: A result appears exactly NUM_LEVELS cycles after its address is accepted. One address is accepted per cycle, and results keep input order.
- R7: A result with no port found has res_hit_o = 0 and res_port_o = 0.
- R8: A write replaces the whole entry at (level, array, index) at the clock edge, and it does not stall lookups. A lookup that reads that entry in the same cycle sees the old word. Level k of a lookup accepted in cycle t is read in cycle t+k.
- R9: Reset clears every entry and the pipeline. No result is valid until an address is accepted, and every lookup then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_vld_i | input | 1 | Address valid |
| lk_addr_i | input | ADDR_W | Destination address |
| wr_en_i | input | 1 | Entry write strobe |
| wr_level_i | input | $clog2(NUM_LEVELS) | Level to write |
| wr_array_i | input | $clog2(NUM_ARRAYS) | Array within the level |
| wr_index_i | input | SLOT_N (max stride) | Entry within the array |
| wr_data_i | input | ENTRY_W | Whole entry word |
| res_vld_o | output | 1 | Result valid |
| res_hit_o | output | 1 | A port was found |
| res_port_o | output | PORT_W | Next-hop port, zero on miss |

## Verification
An entry write and a lookup that reads the same entry can land in the same cycle. The bench provokes this directly in two cases. In the first, a level-0 entry is written in the cycle a lookup enters, and that lookup must see the old word. In the second, a level-2 entry is written in that cycle, and the lookup must see the new word. Each expected result comes from a bench model of the table, updated before or after the expectation according to the read cycle in R8.

// File: rtl/trie_pkg.sv
package trie_pkg;
  localparam int MAX_LEVELS = 8;
  typedef logic [MAX_LEVELS*8-1:0] stride_vec_t;

  function automatic int stride_at(stride_vec_t v, int i);
    return int'(v[i*8 +: 8]);
  endfunction

  // low bit of level i's chunk
  function automatic int shift_at(stride_vec_t v, int i, int addr_w);
    int s = 0;
    for (int k = 0; k <= i; k++) s += int'(v[k*8 +: 8]);
    return addr_w - s;
  endfunction

  function automatic int max_stride(stride_vec_t v, int n);
    int m = 1;
    for (int k = 0; k < n; k++) if (int'(v[k*8 +: 8]) > m) m = int'(v[k*8 +: 8]);
    return m;
  endfunction
endpackage

// File: rtl/trie_level_mem.sv
module trie_level_mem #(
  parameter int LEVEL   = 0,
  parameter int STRIDE  = 4,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 1,
  parameter int LVL_W   = 2,
  parameter int ENTRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LVL_W-1:0]   wr_level_i,
  input  logic [PTR_W-1:0]   wr_array_i,
  input  logic [IDX_W-1:0]   wr_index_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]   rd_array_i,
  input  logic [STRIDE-1:0]  rd_row_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  localparam int AW    = PTR_W + STRIDE;
  localparam int DEPTH = 1 << AW;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic               wr_hit;
  logic [AW-1:0]      wr_addr;

  assign wr_hit  = wr_en_i && (wr_level_i == LVL_W'(LEVEL)) && ((wr_index_i >> STRIDE) == '0);
  assign wr_addr = {wr_array_i, wr_index_i[STRIDE-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_addr] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[{rd_array_i, rd_row_i}];

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> mem[$past(wr_addr)] == $past(wr_data_i)); // R8
endmodule

// File: rtl/trie_stage.sv
module trie_stage #(
  parameter int ADDR_W  = 32,
  parameter int STRIDE  = 4,
  parameter int SHIFT   = 0,
  parameter int SLOT_N  = 4,
  parameter int PORT_W  = 4,
  parameter int PTR_W   = 1,
  parameter int ENTRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               go_i,
  input  logic [PTR_W-1:0]   ptr_i,
  input  logic               skip_i,
  input  logic               found_i,
  input  logic [PORT_W-1:0]  port_i,
  output logic [PTR_W-1:0]   rd_array_o,
  output logic [STRIDE-1:0]  rd_row_o,
  input  logic [ENTRY_W-1:0] rd_data_i,
  output logic               vld_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               go_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               skip_o,
  output logic               found_o,
  output logic [PORT_W-1:0]  port_o
);
  localparam int VLD_LSB  = SLOT_N * PORT_W;
  localparam int PTR_LSB  = VLD_LSB + SLOT_N;
  localparam int IND_BIT  = PTR_LSB + PTR_W;
  localparam int SKIP_BIT = IND_BIT + 1;

  logic [STRIDE-1:0] chunk;
  logic              reach;
  logic [SLOT_N-1:0] slot_vld;
  logic              sel_found;
  logic [PORT_W-1:0] sel_port;
  logic              take;

  assign chunk      = addr_i[SHIFT +: STRIDE];
  assign reach      = go_i && (!skip_i || (chunk == '0));
  assign rd_array_o = ptr_i;
  assign rd_row_o   = skip_i ? '0 : chunk;
  assign slot_vld   = rd_data_i[VLD_LSB +: SLOT_N];

  // longest length in this chunk wins
  always_comb begin
    sel_found = 1'b0;
    sel_port  = '0;
    for (int k = 0; k < STRIDE; k++) begin
      if (slot_vld[k]) begin
        sel_found = 1'b1;
        sel_port  = rd_data_i[k*PORT_W +: PORT_W];
      end
    end
  end

  assign take = reach && sel_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      addr_o  <= '0;
      go_o    <= 1'b0;
      ptr_o   <= '0;
      skip_o  <= 1'b0;
      found_o <= 1'b0;
      port_o  <= '0;
    end else begin
      vld_o   <= vld_i;
      addr_o  <= addr_i;
      go_o    <= reach && rd_data_i[IND_BIT];
      ptr_o   <= rd_data_i[PTR_LSB +: PTR_W];
      skip_o  <= rd_data_i[SKIP_BIT];
      found_o <= found_i || take;
      port_o  <= take ? sel_port : port_i;
    end
  end

  AST_KEEP_FOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && found_i) |=> found_o); // R4
  AST_SKIP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && go_i && skip_i && (chunk != '0)) |=> (!go_o && port_o == $past(port_i))); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !go_i) |=> (!go_o && found_o == $past(found_i) && port_o == $past(port_i))); // R3
endmodule

// File: rtl/trie_lookup.sv
module trie_lookup #(
  parameter int                  ADDR_W     = 32,
  parameter int                  NUM_LEVELS = 4,
  parameter trie_pkg::stride_vec_t STRIDES  = 64'h0000_0000_0808_0808,
  parameter int                  NUM_ARRAYS = 2,  // power of two
  parameter int                  PORT_W     = 4,
  localparam int SLOT_N  = trie_pkg::max_stride(STRIDES, NUM_LEVELS),
  localparam int PTR_W   = $clog2(NUM_ARRAYS),
  localparam int LVL_W   = $clog2(NUM_LEVELS),
  localparam int ENTRY_W = SLOT_N * PORT_W + SLOT_N + PTR_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_vld_i,
  input  logic [ADDR_W-1:0]  lk_addr_i,
  input  logic               wr_en_i,
  input  logic [LVL_W-1:0]   wr_level_i,
  input  logic [PTR_W-1:0]   wr_array_i,
  input  logic [SLOT_N-1:0]  wr_index_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  output logic               res_vld_o,
  output logic               res_hit_o,
  output logic [PORT_W-1:0]  res_port_o
);
  logic [NUM_LEVELS:0]             s_vld, s_go, s_skip, s_found;
  logic [NUM_LEVELS:0][ADDR_W-1:0] s_addr;
  logic [NUM_LEVELS:0][PTR_W-1:0]  s_ptr;
  logic [NUM_LEVELS:0][PORT_W-1:0] s_port;

  assign s_vld[0]   = lk_vld_i;
  assign s_addr[0]  = lk_addr_i;
  assign s_go[0]    = 1'b1;
  assign s_ptr[0]   = '0;
  assign s_skip[0]  = 1'b0;
  assign s_found[0] = 1'b0;
  assign s_port[0]  = '0;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    localparam int STRIDE = trie_pkg::stride_at(STRIDES, g);
    localparam int SHIFT  = trie_pkg::shift_at(STRIDES, g, ADDR_W);
    logic [PTR_W-1:0]   rd_array;
    logic [STRIDE-1:0]  rd_row;
    logic [ENTRY_W-1:0] rd_data;

    trie_level_mem #(
      .LEVEL(g), .STRIDE(STRIDE), .IDX_W(SLOT_N), .PTR_W(PTR_W),
      .LVL_W(LVL_W), .ENTRY_W(ENTRY_W)
    ) u_mem (
      .clk_i, .rst_ni, .wr_en_i, .wr_level_i, .wr_array_i, .wr_index_i, .wr_data_i,
      .rd_array_i(rd_array), .rd_row_i(rd_row), .rd_data_o(rd_data)
    );

    trie_stage #(
      .ADDR_W(ADDR_W), .STRIDE(STRIDE), .SHIFT(SHIFT), .SLOT_N(SLOT_N),
      .PORT_W(PORT_W), .PTR_W(PTR_W), .ENTRY_W(ENTRY_W)
    ) u_stage (
      .clk_i, .rst_ni,
      .vld_i(s_vld[g]), .addr_i(s_addr[g]), .go_i(s_go[g]), .ptr_i(s_ptr[g]),
      .skip_i(s_skip[g]), .found_i(s_found[g]), .port_i(s_port[g]),
      .rd_array_o(rd_array), .rd_row_o(rd_row), .rd_data_i(rd_data),
      .vld_o(s_vld[g+1]), .addr_o(s_addr[g+1]), .go_o(s_go[g+1]), .ptr_o(s_ptr[g+1]),
      .skip_o(s_skip[g+1]), .found_o(s_found[g+1]), .port_o(s_port[g+1])
    );
  end

  logic unused_tail;
  assign unused_tail = ^{s_addr[NUM_LEVELS], s_go[NUM_LEVELS], s_ptr[NUM_LEVELS], s_skip[NUM_LEVELS]};

  assign res_vld_o  = s_vld[NUM_LEVELS];
  assign res_hit_o  = s_found[NUM_LEVELS];
  assign res_port_o = s_port[NUM_LEVELS];

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && !res_hit_o) |-> (res_port_o == '0)); // R7
  AST_VLD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_vld[NUM_LEVELS-1] |=> res_vld_o); // R6
endmodule

// File: tb/trie_lookup_bench.sv
`timescale 1ns/1ps
module trie_lookup_bench;
  localparam int AW = 12;
  localparam int NL = 3;
  localparam int NA = 4;
  localparam int PW = 4;
  localparam int EW = 24;
  localparam trie_pkg::stride_vec_t ST = 64'h0000_0000_0004_0404;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_vld = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_level = '0;
  logic [1:0]    wr_array = '0;
  logic [3:0]    wr_index = '0;
  logic [EW-1:0] wr_data = '0;
  logic          res_vld, res_hit;
  logic [PW-1:0] res_port;

  always #2 clk = ~clk;

  trie_lookup #(.ADDR_W(AW), .NUM_LEVELS(NL), .STRIDES(ST), .NUM_ARRAYS(NA), .PORT_W(PW))
  u_trie_lookup (
    .clk_i(clk), .rst_ni(rst_n), .lk_vld_i(lk_vld), .lk_addr_i(lk_addr),
    .wr_en_i(wr_en), .wr_level_i(wr_level), .wr_array_i(wr_array), .wr_index_i(wr_index),
    .wr_data_i(wr_data), .res_vld_o(res_vld), .res_hit_o(res_hit), .res_port_o(res_port)
  );

  logic [EW-1:0] model [NL][NA][16];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit          q_hit [$];
  logic [3:0]  q_port [$];
  logic [11:0] q_addr [$];
  string       q_tag [$];

  // layout: skip[23] ind[22] ptr[21:20] vld[19:16] ports[15:0]
  function automatic logic [EW-1:0] mk(bit sk, bit ind, logic [1:0] ptr, logic [3:0] vld, logic [15:0] ports);
    return {sk, ind, ptr, vld, ports};
  endfunction

  function automatic void ref_lookup(logic [11:0] a, output bit hit, output logic [3:0] port);
    bit go = 1'b1;
    bit sk = 1'b0;
    logic [1:0] ptr = '0;
    logic [3:0] chunk, row;
    logic [EW-1:0] e;
    hit = 1'b0;
    port = '0;
    for (int lv = 0; lv < NL; lv++) begin
      chunk = a[AW-1-4*lv -: 4];
      if (!go) break;
      if (sk && chunk != 4'd0) break;
      row = sk ? 4'd0 : chunk;
      e = model[lv][ptr][row];
      for (int k = 3; k >= 0; k--) begin
        if (e[16+k]) begin
          hit = 1'b1;
          port = e[k*4 +: 4];
          break;
        end
      end
      go = e[22];
      ptr = e[21:20];
      sk = e[23];
    end
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(bit do_wr, int lvl, int arr, int idx, logic [EW-1:0] data,
                      bit do_lk, logic [11:0] addr, string tag);
    bit h;
    logic [3:0] p;
    wr_en = do_wr; wr_level = 2'(lvl); wr_array = 2'(arr); wr_index = 4'(idx); wr_data = data;
    lk_vld = do_lk; lk_addr = addr;
    if (do_wr && lvl >= 1) model[lvl][arr][idx] = data;  // read after the edge: new word
    if (do_lk) begin
      ref_lookup(addr, h, p);
      q_hit.push_back(h); q_port.push_back(p); q_addr.push_back(addr); q_tag.push_back(tag);
    end
    if (do_wr && lvl == 0) model[lvl][arr][idx] = data;  // read this cycle: old word
    @(negedge clk);
    wr_en = 1'b0;
    lk_vld = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step(0, 0, 0, 0, '0, 0, '0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (q_hit.size() == 0) begin
        check(1'b0, "R6 unexpected result", 1, 0);
      end else begin
        bit eh;
        logic [3:0] ep;
        logic [11:0] ea;
        string et;
        eh = q_hit.pop_front(); ep = q_port.pop_front(); ea = q_addr.pop_front(); et = q_tag.pop_front();
        check(res_hit == eh, $sformatf("%s hit addr=%0h", et, ea), int'(res_hit), int'(eh));
        check(res_port == ep, $sformatf("%s port addr=%0h", et, ea), int'(res_port), int'(ep));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++)
      for (int a = 0; a < NA; a++)
        for (int r = 0; r < 16; r++) model[l][a][r] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_vld == 1'b0, "R9 reset valid", int'(res_vld), 0);
    check(res_hit == 1'b0, "R9 reset hit", int'(res_hit), 0);

    // R9 R7: empty table misses
    step(0, 0, 0, 0, '0, 1, 12'h3A5, "R9 R7 empty table");
    step(0, 0, 0, 0, '0, 1, 12'h000, "R9 R7 empty table");
    idle(4);

    // directed table
    step(1, 0, 0, 3, mk(0, 1, 2'd1, 4'b0010, 16'h0050), 0, '0, "");
    step(1, 1, 1, 0, mk(1, 1, 2'd2, 4'b0100, 16'h0900), 0, '0, "");
    step(1, 2, 2, 0, mk(0, 0, 2'd0, 4'b1000, 16'hC000), 0, '0, "");
    step(1, 0, 0, 8, mk(0, 0, 2'd0, 4'b0101, 16'h0701), 0, '0, "");

    // R6 latency: result visible after the third edge
    step(0, 0, 0, 0, '0, 1, 12'h300, "R5 R6 skip into zero chunk");
    @(negedge clk);
    check(res_vld == 1'b0, "R6 early result", int'(res_vld), 0);
    @(negedge clk);
    check(res_vld == 1'b1, "R6 result at latency", int'(res_vld), 1);
    idle(3);

    // back to back, order kept
    step(0, 0, 0, 0, '0, 1, 12'h305, "R5 skip with nonzero chunk");
    step(0, 0, 0, 0, '0, 1, 12'h310, "R4 deeper level empty keeps port");
    step(0, 0, 0, 0, '0, 1, 12'h700, "R7 miss");
    step(0, 0, 0, 0, '0, 1, 12'h8AB, "R2 highest slot wins");
    step(0, 0, 0, 0, '0, 1, 12'h300, "R4 R3 deepest port");
    step(0, 0, 0, 0, '0, 1, 12'h2FF, "R1 R7 other chunk miss");
    idle(4);

    // R8: same-cycle write and lookup
    step(1, 0, 0, 11, mk(0, 0, 2'd0, 4'b1000, 16'h6000), 1, 12'hB00, "R8 level0 write same cycle old");
    step(0, 0, 0, 0, '0, 1, 12'hB00, "R8 level0 write seen next");
    idle(4);
    step(1, 2, 2, 0, mk(0, 0, 2'd0, 4'b1000, 16'hD000), 1, 12'h300, "R8 level2 write same cycle new");
    idle(4);

    // random rounds: writes, then lookups, then drain
    for (int round = 0; round < 4; round++) begin
      repeat (40) begin
        logic [EW-1:0] d;
        d = mk(($urandom % 4) == 0, ($urandom % 10) < 7, 2'($urandom), 4'($urandom), 16'($urandom));
        step(1, int'($urandom % NL), int'($urandom % NA), int'($urandom % 16), d, 0, '0, "");
      end
      repeat (150) begin
        logic [11:0] a;
        a = 12'($urandom);
        if (($urandom % 3) == 0) a[3:0] = 4'd0;
        if (($urandom % 3) == 0) a[7:4] = 4'd0;
        step(0, 0, 0, 0, '0, 1, a, "R1 R2 R3 R4 R5 random");
      end
      idle(5);
    end

    check(q_hit.size() == 0, "R6 missing results", q_hit.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule